// File: doc/BRIEF.md
# I2C Clock Period Generator

This block produces the serial clock of an I2C controller from counts of system-clock cycles. It holds the line low for a timed interval, lets it go, waits until the line is seen high, and then times the high interval before pulling low again. The output is an open-drain style pull request: when `scl_pull` is 1 the pad pulls the clock line low; when it is 0 the line floats and the pull-up (or a target) decides its level. The level actually on the line comes back on `scl_in`.

Three pairs of high/low counts are available, one per bus speed, and a 2-bit speed request picks the pair. The counts and the speed request are captured only while the block is disabled, so software programs them with `gen_en` low and then raises `gen_en`. A high-speed request on a build without high-speed support falls back to the fast pair. `clk_run` asks for clock pulses; dropping it lets the current period finish and then leaves the line released.

Top module: `scl_period_gen`

## Requirements
- R1: During and after reset the block does not pull the line (`scl_pull` = 0) until it is enabled and asked to run.
- R2: Each low phase lasts exactly the selected low count plus 1 cycles (`scl_pull` = 1), counted from the cycle the block starts pulling, whatever level `scl_in` shows meanwhile.
- R3: Each high phase lasts the selected high count plus 8 cycles counted from the first cycle `scl_in` is sampled high after release; while a target holds the line low the release is extended by the same number of cycles.
- R4: Speed request encoding: 0 and 1 select the standard pair, 2 the fast pair, 3 the high-speed pair.
- R5: With parameter `HS_OK` = 0, a speed request of 3 uses the fast pair.
- R6: Any count below 6 is used as 6.
- R7: Counts and speed request are sampled only while `gen_en` is 0; changes while enabled have no effect until the block is disabled and enabled again.
- R8: Lowering `gen_en` releases the line at the next clock edge and keeps it released.
- R9: With `gen_en` high, raising `clk_run` starts a low phase at the next edge; lowering it lets the current low and high phases complete, after which the line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Block enable; counts are captured while low |
| clk_run | input | 1 | Request for clock pulses |
| speed_req | input | 2 | Speed select: 0/1 standard, 2 fast, 3 high speed |
| std_hi | input | 16 | Standard high count |
| std_lo | input | 16 | Standard low count |
| fast_hi | input | 16 | Fast high count |
| fast_lo | input | 16 | Fast low count |
| hs_hi | input | 16 | High-speed high count |
| hs_lo | input | 16 | High-speed low count |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_pull | output | 1 | 1 = pull the clock line low |

## Verification
The pull output is a state decode, so a start request appears one edge after it is applied and a disable takes effect at the very next edge; the bench drives at falling edges and samples the following falling edge. Phase lengths are measured as runs of consecutive falling-edge samples of `scl_pull`, so a low phase is expected as low count plus 1 samples and a release as high count plus 8 plus any cycles the line model holds the clock low. The line model feeds `scl_in` back from the registered pull through registered stretch logic, so each run length is fixed by the requirements alone.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int NMODE      = 3;
  localparam int MIN_CNT    = 6;
  localparam int LOW_EXTRA  = 1;
  localparam int HIGH_EXTRA = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  // pair index: 0 standard, 1 fast, 2 high speed
  function automatic logic [1:0] pick_pair(input logic [1:0] req, input bit hs_ok);
    case (req)
      2'd2:    pick_pair = 2'd1;
      2'd3:    pick_pair = hs_ok ? 2'd2 : 2'd1;
      default: pick_pair = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit HS_OK = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [1:0]             speed_req,
  input  logic [NMODE*CNT_W-1:0] hi_all,
  input  logic [NMODE*CNT_W-1:0] lo_all,
  output logic [CNT_W-1:0]       hi_q,
  output logic [CNT_W-1:0]       lo_q
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

  logic [CNT_W-1:0] hi_cl [NMODE];
  logic [CNT_W-1:0] lo_cl [NMODE];
  logic [1:0]       pair;
  logic [CNT_W-1:0] hi_d, lo_d;
  logic             ld;

  for (genvar m = 0; m < NMODE; m++) begin : g_clamp
    always_comb begin
      hi_cl[m] = hi_all[m*CNT_W +: CNT_W];
      lo_cl[m] = lo_all[m*CNT_W +: CNT_W];
      if (hi_cl[m] < FLOOR) hi_cl[m] = FLOOR;
      if (lo_cl[m] < FLOOR) lo_cl[m] = FLOOR;
    end
  end

  always_comb begin
    pair = pick_pair(speed_req, HS_OK);
    ld   = ~en;
    hi_d = hi_cl[0];
    lo_d = lo_cl[0];
    for (int m = 1; m < NMODE; m++) begin
      if (pair == 2'(m)) begin
        hi_d = hi_cl[m];
        lo_d = lo_cl[m];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= FLOOR;
      lo_q <= FLOOR;
    end else if (ld) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  // R6: the timer never sees a count under the floor
  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q >= FLOOR) && (lo_q >= FLOOR));

  // R7: captured counts stay put while enabled
  p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(hi_q) && $stable(lo_q)));

  if (!HS_OK) begin : g_no_hs
    // R5: the high-speed pair is never chosen on this build
    p_no_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pair != 2'd2);
  end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  output logic             pull
);
  localparam int PH_W = CNT_W + 1;
  // low phase: LOW_EXTRA + lo cycles, counter loaded with length-1
  localparam logic [PH_W-1:0] LO_ADD = PH_W'(LOW_EXTRA - 1);
  // high phase: first seen-high cycle is spent in PH_WAIT
  localparam logic [PH_W-1:0] HI_ADD = PH_W'(HIGH_EXTRA - 2);

  phase_t          st_q, st_n;
  logic [PH_W-1:0] cnt_q, cnt_n;
  logic [PH_W-1:0] lo_load, hi_load;
  logic            cnt_zero;

  assign lo_load  = PH_W'(lo_cnt) + LO_ADD;
  assign hi_load  = PH_W'(hi_cnt) + HI_ADD;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      PH_IDLE: if (run) begin
        st_n  = PH_LOW;
        cnt_n = lo_load;
      end
      PH_LOW: begin
        if (cnt_zero) st_n = PH_WAIT;
        else          cnt_n = cnt_q - 1'b1;
      end
      PH_WAIT: if (scl_in) begin
        st_n  = PH_HIGH;
        cnt_n = hi_load;
      end
      PH_HIGH: begin
        if (!cnt_zero) begin
          cnt_n = cnt_q - 1'b1;
        end else if (run) begin
          st_n  = PH_LOW;
          cnt_n = lo_load;
        end else begin
          st_n = PH_IDLE;
        end
      end
      default: st_n = PH_IDLE;
    endcase
    if (!en) begin
      st_n  = PH_IDLE;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign pull = (st_q == PH_LOW);

  // R8: disable releases the line at the next edge
  p_release_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pull);

  // R9: an idle, enabled block asked to run pulls at the next edge
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_IDLE && en && run) |=> pull);

  // R3: a line held low keeps the block from timing the high phase
  p_wait_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_WAIT && !scl_in && en) |=> (st_q == PH_WAIT && !pull));

  // R2: the low phase never ends with a non-zero count
  p_low_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_LOW && !cnt_zero && en) |=> pull);
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit HS_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             clk_run,
  input  logic [1:0]       speed_req,
  input  logic [CNT_W-1:0] std_hi,
  input  logic [CNT_W-1:0] std_lo,
  input  logic [CNT_W-1:0] fast_hi,
  input  logic [CNT_W-1:0] fast_lo,
  input  logic [CNT_W-1:0] hs_hi,
  input  logic [CNT_W-1:0] hs_lo,
  input  logic             scl_in,
  output logic             scl_pull
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [CNT_W-1:0] hi_sel, lo_sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  scl_cfg_latch #(.CNT_W(CNT_W), .HS_OK(HS_OK)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (gen_en),
    .speed_req (speed_req),
    .hi_all    ({hs_hi, fast_hi, std_hi}),
    .lo_all    ({hs_lo, fast_lo, std_lo}),
    .hi_q      (hi_sel),
    .lo_q      (lo_sel)
  );

  scl_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (gen_en),
    .run    (clk_run),
    .scl_in (scl_in),
    .hi_cnt (hi_sel),
    .lo_cnt (lo_sel),
    .pull   (scl_pull)
  );

  // R1: no pull while reset is applied
  always_comb begin
    if (!rst_n) p_reset_idle_r1: assert (!scl_pull);
  end
endmodule

// File: tb/scl_period_gen_bench.sv
module scl_period_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_en = 1'b0, clk_run = 1'b0;
  logic [1:0] speed_req = 2'd0;
  logic [15:0] std_hi = 16'd40, std_lo = 16'd50;
  logic [15:0] fast_hi = 16'd12, fast_lo = 16'd3;
  logic [15:0] hs_hi = 16'd2, hs_lo = 16'd9;
  logic pull_a, pull_b, line_a, line_b;
  logic [7:0] hold_cnt = 8'd0;
  logic [7:0] hold_amt = 8'd0;
  logic float_hi = 1'b0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  // line model: target may hold the line low after release; float_hi
  // models a line that never falls while pulled
  always @(posedge clk) begin
    if (pull_a) hold_cnt <= hold_amt;
    else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
  end
  assign line_a = (float_hi || !pull_a) && (hold_cnt == 0);
  assign line_b = !pull_b;

  scl_period_gen u_scl_period_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .clk_run(clk_run),
    .speed_req(speed_req), .std_hi(std_hi), .std_lo(std_lo),
    .fast_hi(fast_hi), .fast_lo(fast_lo), .hs_hi(hs_hi), .hs_lo(hs_lo),
    .scl_in(line_a), .scl_pull(pull_a));

  scl_period_gen #(.HS_OK(1'b0)) u_scl_period_gen_nohs (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .clk_run(clk_run),
    .speed_req(speed_req), .std_hi(std_hi), .std_lo(std_lo),
    .fast_hi(fast_hi), .fast_lo(fast_lo), .hs_hi(hs_hi), .hs_lo(hs_lo),
    .scl_in(line_b), .scl_pull(pull_b));

  // inst, speed, expected low cycles, expected released cycles
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 51, 48},   // R4 code 0 -> standard
    '{0, 1, 51, 48},   // R4 standard
    '{0, 2, 7, 20},    // R4 fast, R6 low 3 -> 6
    '{0, 3, 10, 14},   // R4 high speed, R6 high 2 -> 6
    '{1, 3, 7, 20},    // R5 refused -> fast
    '{1, 2, 7, 20}     // R4 fast on second build
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input bit which, output int lo_len, output int hi_len);
    lo_len = 0;
    hi_len = 0;
    while (!(which ? pull_b : pull_a)) @(negedge clk);
    while (which ? pull_b : pull_a) begin lo_len++; @(negedge clk); end
    while (!(which ? pull_b : pull_a)) begin hi_len++; @(negedge clk); end
  endtask

  task automatic restart(input logic [1:0] spd);
    gen_en = 1'b0;
    clk_run = 1'b0;
    speed_req = spd;
    repeat (3) @(negedge clk);
    gen_en = 1'b1;
    clk_run = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lo, hi, cnt;
    repeat (3) @(negedge clk);
    check("R1 pull in reset", int'(pull_a | pull_b), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 pull after reset", int'(pull_a | pull_b), 0);

    for (int i = 0; i < NVEC; i++) begin
      restart(VEC[i][1][1:0]);
      @(negedge clk);
      check("R9 start next edge", int'(VEC[i][0] ? pull_b : pull_a), 1);
      measure(VEC[i][0] != 0, lo, hi);
      check("R2/R4/R5/R6 low length", lo, VEC[i][2]);
      check("R3/R4/R5/R6 high length", hi, VEC[i][3]);
    end

    // R7: count changed while enabled is ignored until re-enable
    restart(2'd0);
    measure(1'b0, lo, hi);
    std_lo = 16'd100;
    speed_req = 2'd2;
    measure(1'b0, lo, hi);
    check("R7 low ignores live change", lo, 51);
    check("R7 high ignores live change", hi, 48);
    restart(2'd0);
    measure(1'b0, lo, hi);
    check("R7 low after re-enable", lo, 101);
    std_lo = 16'd50;

    // R3: target stretches the clock
    restart(2'd0);
    hold_amt = 8'd10;
    measure(1'b0, lo, hi);
    measure(1'b0, lo, hi);
    check("R3 stretched high", hi, 58);
    hold_amt = 8'd0;

    // R2: low timing independent of line level
    float_hi = 1'b1;
    measure(1'b0, lo, hi);
    measure(1'b0, lo, hi);
    check("R2 low with line floating high", lo, 51);
    float_hi = 1'b0;

    // R8: disable mid-low releases at once and stays released
    measure(1'b0, lo, hi);
    gen_en = 1'b0;
    @(negedge clk);
    check("R8 release next edge", int'(pull_a), 0);
    cnt = 0;
    repeat (30) begin @(negedge clk); cnt += int'(pull_a); end
    check("R8 stays released", cnt, 0);

    // R9: drop run at start of a low phase; the period completes
    restart(2'd0);
    measure(1'b0, lo, hi);
    clk_run = 1'b0;
    cnt = 0;
    repeat (200) begin @(negedge clk); cnt += int'(pull_a); end
    check("R9 current low completes", cnt, 50);
    cnt = 0;
    repeat (100) begin @(negedge clk); cnt += int'(pull_a); end
    check("R9 idle after run dropped", cnt, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule